// File: doc/BRIEF.md
# Watchdog Safe-State Supervisor

This block supervises a control compute domain from outside it. A window watchdog expects one service strobe per period, and that strobe is only accepted once a programmable opening delay has passed and before a programmable deadline. A strobe that comes too soon counts as a fault, and so does a missing strobe. The block also watches a power-good input, an over-temperature flag and two fault requests, one from an external source and one from software. It moves through four recovery states: RUN, WARN, SAFE and LOCKOUT.

Any fault drives the safe-output override and asserts the compute-domain reset. The block records why it acted and charges the fault against a retry budget. Reset is released only after power-good has stayed high for a programmed number of cycles, followed by a fixed minimum pulse. If faults come faster than the budget allows, the block stops retrying and parks in LOCKOUT. LOCKOUT holds until power is stable and an operator acknowledge arrives. The override is a direct logic path from state and power-good, and firmware plays no part in it.

Top module: `wdog_safe_supervisor`

## Requirements
- R1: A service strobe sampled while the watchdog count since the last restart is below `cfg_open_i` is an early fault. A count that reaches `cfg_timeout_i` with no accepted strobe is a timeout fault. A strobe with a count in [`cfg_open_i`, `cfg_timeout_i`) is accepted and restarts the count. Both kinds of fault record cause 1.
- R2: A fault in RUN or WARN moves the block to SAFE (state 2), or to LOCKOUT if R5 applies, on the next clock edge. In either state the block asserts `safe_force_o`, drives `comp_rst_n_o` low and adds one to the retry count.
- R3: `safe_force_o` is high and `comp_rst_n_o` is low whenever the state is SAFE or LOCKOUT, or `pgood_i` is low. The override follows `pgood_i` within the same cycle, with no register between them.
- R4: SAFE leaves for RUN only after `pgood_i` has been high for at least `cfg_pg_stable_i` consecutive cycles (the setting must be at least 1), followed by RST_PULSE further cycles. Reset stays asserted for as long as `pgood_i` stays low.
- R5: If a fault would raise the retry count above `cfg_retry_limit_i`, the block enters LOCKOUT (state 3) instead of SAFE, and the count shows limit+1.
- R6: LOCKOUT persists with no time limit. It is left, to SAFE, only on a cycle where `ack_i` is high and power-good is stable as in R4. That transition clears the retry count. An acknowledge sent while power is low or not yet stable has no effect.
- R7: The cause register reads 0 unknown, 1 watchdog, 2 brownout, 3 external, 4 software. If several causes occur in the same cycle, brownout wins over watchdog, watchdog over external, and external over software. The register changes only when a fault is taken. It keeps its value across the compute reset that the block itself drives.
- R8: RUN moves to WARN (state 1) when the watchdog count reaches `cfg_timeout_i - cfg_timeout_i/4` or when `overtemp_i` is high. WARN returns to RUN (state 0) once a strobe has been accepted or over-temperature has cleared, provided the other condition does not hold.
- R9: The first fault of a retry window starts a window counter of `cfg_retry_win_i` cycles. When the window expires, the retry count returns to 0, and the next fault counts as 1 again. The window is frozen during LOCKOUT.
- R10: While `rst_n` is low, the state is SAFE, the cause is 0, the retry count is 0, `safe_force_o` is high and `comp_rst_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Watchdog service strobe, one cycle |
| pgood_i | input | 1 | Power-good from the rail monitor |
| overtemp_i | input | 1 | Over-temperature flag |
| ack_i | input | 1 | Operator acknowledge for leaving lockout |
| ext_fault_i | input | 1 | External fault request |
| sw_fault_i | input | 1 | Software fault request |
| cfg_open_i | input | CNT_W | Cycles before the service window opens |
| cfg_timeout_i | input | CNT_W | Watchdog deadline in cycles |
| cfg_pg_stable_i | input | PG_W | Power-good debounce length, at least 1 |
| cfg_retry_limit_i | input | RETRY_W | Faults allowed per retry window |
| cfg_retry_win_i | input | WIN_W | Retry window length, at least 1 |
| comp_rst_n_o | output | 1 | Active-low reset to the compute domain |
| safe_force_o | output | 1 | Forces all field outputs to the safe pattern |
| state_o | output | 2 | 0 RUN, 1 WARN, 2 SAFE, 3 LOCKOUT |
| cause_o | output | 3 | Recorded reset cause |
| retry_cnt_o | output | RETRY_W | Faults in the current retry window |

## Verification
On every cycle, the assertions check the following. LOCKOUT is never left without an acknowledge and stable power. SAFE never releases to RUN unless power was stable in the cycle before. A watchdog timeout in RUN or WARN always lands in SAFE or LOCKOUT. Every entry into LOCKOUT shows a retry count above the limit. The cause and the retry count change only on a fault, a clear or a window expiry. A stable power-good always has a high power-good behind it. Some behaviours need whole scenarios and are left to the bench: the early-versus-timeout distinction, the WARN thresholds, the ignored acknowledges, the cause priority, the cause persisting across the block's own reset, and the expiry of the retry window after many valid services.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WARN = 2'd1,
    ST_SAFE = 2'd2,
    ST_LOCK = 2'd3
  } wss_state_e;

  typedef enum logic [2:0] {
    CZ_UNKNOWN = 3'd0,
    CZ_WDOG    = 3'd1,
    CZ_BROWN   = 3'd2,
    CZ_EXT     = 3'd3,
    CZ_SW      = 3'd4
  } wss_cause_e;
endpackage

// File: rtl/wss_window_wdog.sv
module wss_window_wdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] open_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             early_o,
  output logic             late_o,
  output logic             warn_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, warn_thr;
  logic             ok_kick;

  always_comb begin
    warn_thr = limit_i - (limit_i >> 2);
    ok_kick  = en_i && kick_i && (cnt_q >= open_i) && (cnt_q < limit_i);
    early_o  = en_i && kick_i && (cnt_q < open_i);
    late_o   = en_i && (cnt_q >= limit_i);
    warn_o   = en_i && (cnt_q >= warn_thr);
    if (!en_i || ok_kick) begin
      cnt_d = '0;
    end else if (cnt_q < limit_i) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1
  restart_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/wss_pg_filter.sv
module wss_pg_filter #(
  parameter int PG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pgood_i,
  input  logic [PG_W-1:0] len_i,
  output logic            stable_o
);
  logic [PG_W-1:0] run_q, run_d;

  always_comb begin
    if (!pgood_i)          run_d = '0;
    else if (run_q < len_i) run_d = run_q + PG_W'(1);
    else                   run_d = run_q;
    stable_o = pgood_i && (run_q >= len_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // R4
  stable_has_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stable_o && len_i != '0) |-> $past(pgood_i));
endmodule

// File: rtl/wss_retry_budget.sv
module wss_retry_budget #(
  parameter int RETRY_W = 4,
  parameter int WIN_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic               clear_i,
  input  logic               freeze_i,
  input  logic [RETRY_W-1:0] limit_i,
  input  logic [WIN_W-1:0]   win_i,
  output logic [RETRY_W-1:0] cnt_o,
  output logic               exceed_o
);
  logic [RETRY_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0]   wcnt_q, wcnt_d;
  logic               act_q, act_d;
  logic               win_exp, fresh;
  logic [RETRY_W:0]   cand;

  always_comb begin
    win_exp  = act_q && (wcnt_q == win_i - WIN_W'(1));
    fresh    = !act_q || win_exp;
    cand     = fresh ? (RETRY_W+1)'(1) : ({1'b0, cnt_q} + (RETRY_W+1)'(1));
    exceed_o = cand > {1'b0, limit_i};
    cnt_d    = cnt_q;
    wcnt_d   = wcnt_q;
    act_d    = act_q;
    if (clear_i) begin
      cnt_d  = '0;
      wcnt_d = '0;
      act_d  = 1'b0;
    end else if (fault_i) begin
      cnt_d  = cand[RETRY_W] ? '1 : cand[RETRY_W-1:0];
      act_d  = 1'b1;
      wcnt_d = fresh ? '0 : wcnt_q + WIN_W'(1);
    end else if (!freeze_i && act_q) begin
      if (win_exp) begin
        cnt_d  = '0;
        wcnt_d = '0;
        act_d  = 1'b0;
      end else begin
        wcnt_d = wcnt_q + WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wcnt_q <= '0;
      act_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wcnt_q <= wcnt_d;
      act_q  <= act_d;
    end
  end

  assign cnt_o = cnt_q;

  // R9
  retry_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_i && !clear_i && !win_exp) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_safe_supervisor.sv
module wdog_safe_supervisor
  import wss_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PG_W      = 8,
  parameter int RETRY_W   = 4,
  parameter int WIN_W     = 16,
  parameter int RST_PULSE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               kick_i,
  input  logic               pgood_i,
  input  logic               overtemp_i,
  input  logic               ack_i,
  input  logic               ext_fault_i,
  input  logic               sw_fault_i,
  input  logic [CNT_W-1:0]   cfg_open_i,
  input  logic [CNT_W-1:0]   cfg_timeout_i,
  input  logic [PG_W-1:0]    cfg_pg_stable_i,
  input  logic [RETRY_W-1:0] cfg_retry_limit_i,
  input  logic [WIN_W-1:0]   cfg_retry_win_i,
  output logic               comp_rst_n_o,
  output logic               safe_force_o,
  output logic [1:0]         state_o,
  output logic [2:0]         cause_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);
  localparam int REL_W = $clog2(RST_PULSE + 1);
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RST_PULSE - 1);

  wss_state_e       state_q, state_d;
  wss_cause_e       cause_q, cause_d, cause_sel;
  logic [REL_W-1:0] rel_q, rel_d;
  logic             active, fault, wd_fault, lock_release;
  logic             wd_early, wd_late, wd_warn, pg_ok, retry_exceed;

  assign active = (state_q == ST_RUN) || (state_q == ST_WARN);

  wss_window_wdog #(.CNT_W(CNT_W)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (active),
    .kick_i  (kick_i),
    .open_i  (cfg_open_i),
    .limit_i (cfg_timeout_i),
    .early_o (wd_early),
    .late_o  (wd_late),
    .warn_o  (wd_warn)
  );

  wss_pg_filter #(.PG_W(PG_W)) u_pgf (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgood_i  (pgood_i),
    .len_i    (cfg_pg_stable_i),
    .stable_o (pg_ok)
  );

  wss_retry_budget #(.RETRY_W(RETRY_W), .WIN_W(WIN_W)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_i  (fault),
    .clear_i  (lock_release),
    .freeze_i (state_q == ST_LOCK),
    .limit_i  (cfg_retry_limit_i),
    .win_i    (cfg_retry_win_i),
    .cnt_o    (retry_cnt_o),
    .exceed_o (retry_exceed)
  );

  always_comb begin
    wd_fault = wd_early || wd_late;
    fault    = active && (!pgood_i || wd_fault || ext_fault_i || sw_fault_i);
    if (!pgood_i)         cause_sel = CZ_BROWN;
    else if (wd_fault)    cause_sel = CZ_WDOG;
    else if (ext_fault_i) cause_sel = CZ_EXT;
    else                  cause_sel = CZ_SW;
  end

  always_comb begin
    state_d      = state_q;
    cause_d      = cause_q;
    rel_d        = '0;
    lock_release = 1'b0;
    case (state_q)
      ST_RUN, ST_WARN: begin
        if (fault) begin
          cause_d = cause_sel;
          state_d = retry_exceed ? ST_LOCK : ST_SAFE;
        end else begin
          state_d = (wd_warn || overtemp_i) ? ST_WARN : ST_RUN;
        end
      end
      ST_SAFE: begin
        if (pg_ok) begin
          if (rel_q == REL_LAST) state_d = ST_RUN;
          else                   rel_d   = rel_q + REL_W'(1);
        end
      end
      ST_LOCK: begin
        if (ack_i && pg_ok) begin
          state_d      = ST_SAFE;
          lock_release = 1'b1;
        end
      end
      default: state_d = ST_SAFE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SAFE;
      cause_q <= CZ_UNKNOWN;
      rel_q   <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      rel_q   <= rel_d;
    end
  end

  assign safe_force_o = !active || !pgood_i;
  assign comp_rst_n_o = active && pgood_i;
  assign state_o      = state_q;
  assign cause_o      = cause_q;

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOCK && !(ack_i && pg_ok)) |=> (state_q == ST_LOCK));

  // R4
  release_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SAFE) |=> (state_q != ST_RUN || $past(pg_ok)));

  // R2
  timeout_forces_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && wd_late) |=> (state_q == ST_SAFE || state_q == ST_LOCK));

  // R5
  lock_over_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_LOCK) |-> (retry_cnt_o > cfg_retry_limit_i));

  // R7
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |=> $stable(cause_q));
endmodule

// File: tb/wdog_safe_supervisor_bench.sv
module wdog_safe_supervisor_bench;
  localparam int CNT_W = 16, PG_W = 8, RETRY_W = 4, WIN_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, kick, pgood, otemp, ack, extf, swf;
  logic [CNT_W-1:0]   cfg_open, cfg_to;
  logic [PG_W-1:0]    cfg_pg;
  logic [RETRY_W-1:0] cfg_lim;
  logic [WIN_W-1:0]   cfg_win;
  logic               comp_rst_n, safe_force;
  logic [1:0]         state;
  logic [2:0]         cause;
  logic [RETRY_W-1:0] retry;

  wdog_safe_supervisor #(.CNT_W(CNT_W), .PG_W(PG_W), .RETRY_W(RETRY_W),
                         .WIN_W(WIN_W), .RST_PULSE(4)) u_wdog_safe_supervisor (
    .clk(clk), .rst_n(rst_n), .kick_i(kick), .pgood_i(pgood), .overtemp_i(otemp),
    .ack_i(ack), .ext_fault_i(extf), .sw_fault_i(swf),
    .cfg_open_i(cfg_open), .cfg_timeout_i(cfg_to), .cfg_pg_stable_i(cfg_pg),
    .cfg_retry_limit_i(cfg_lim), .cfg_retry_win_i(cfg_win),
    .comp_rst_n_o(comp_rst_n), .safe_force_o(safe_force), .state_o(state),
    .cause_o(cause), .retry_cnt_o(retry)
  );

  int n_chk = 0, n_fail = 0;
  int q_st[$], q_cz[$], q_rt[$], q_sf[$], q_rn[$];
  string q_tag[$];

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin : monitor
    int e_st, e_cz, e_rt, e_sf, e_rn;
    string tg;
    if (q_st.size() > 0) begin
      e_st = q_st.pop_front(); e_cz = q_cz.pop_front(); e_rt = q_rt.pop_front();
      e_sf = q_sf.pop_front(); e_rn = q_rn.pop_front(); tg = q_tag.pop_front();
      n_chk++;
      if ((e_st >= 0 && int'(state) != e_st) || (e_cz >= 0 && int'(cause) != e_cz) ||
          (e_rt >= 0 && int'(retry) != e_rt) || (e_sf >= 0 && int'(safe_force) != e_sf) ||
          (e_rn >= 0 && int'(comp_rst_n) != e_rn)) begin
        n_fail++;
        $display("FAIL %s: got st=%0d cause=%0d retry=%0d safe=%0d rstn=%0d expected st=%0d cause=%0d retry=%0d safe=%0d rstn=%0d",
                 tg, state, cause, retry, safe_force, comp_rst_n, e_st, e_cz, e_rt, e_sf, e_rn);
      end
    end
  end

  task automatic expect_now(input int st, input int cz, input int rt, input int sf,
                            input int rn, input string tag);
    q_st.push_back(st); q_cz.push_back(cz); q_rt.push_back(rt);
    q_sf.push_back(sf); q_rn.push_back(rn); q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_kick();
    kick = 1'b1; cyc(1); kick = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  task automatic serve(input int n);
    cyc(n); pulse_kick();
  endtask

  task automatic wait_state(input int st, input int maxc, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < maxc && !seen; i++) begin
      @(negedge clk);
      if (int'(state) == st) seen = 1'b1;
    end
    n_chk++;
    if (!seen) begin
      n_fail++;
      $display("FAIL %s: got state=%0d expected state=%0d", tag, state, st);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got run still active expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    rst_n = 1'b0; kick = 1'b0; pgood = 1'b0; otemp = 1'b0; ack = 1'b0;
    extf = 1'b0; swf = 1'b0;
    cfg_open = 16'd20; cfg_to = 16'd40; cfg_pg = 8'd8; cfg_lim = 4'd2; cfg_win = 16'd2000;
    cyc(3);
    expect_now(2, 0, 0, 1, 0, "R10 reset state");
    rst_n = 1'b1; pgood = 1'b1;
    cyc(5);
    expect_now(2, 0, 0, 1, 0, "R4 reset held before power stable");
    cyc(15);
    expect_now(0, 0, 0, 0, 1, "R4 released to run");

    // valid services
    serve(17); cyc(2);
    expect_now(0, 0, 0, 0, 1, "R1 valid kick keeps run");
    serve(22); cyc(2);
    expect_now(0, 0, 0, 0, 1, "R1 second valid kick");

    // warn at three quarters of the timeout
    cyc(33);
    expect_now(1, 0, 0, 0, 1, "R8 warn near deadline");
    pulse_kick(); cyc(2);
    expect_now(0, 0, 0, 0, 1, "R8 warn cleared by kick");

    // over-temperature
    cyc(3); otemp = 1'b1; cyc(3);
    expect_now(1, 0, 0, 0, 1, "R8 overtemp warn");
    otemp = 1'b0; cyc(2);
    expect_now(0, 0, 0, 0, 1, "R8 overtemp cleared");
    serve(12); cyc(1);

    // early kick
    cyc(4); pulse_kick();
    expect_now(2, 1, 1, 1, 0, "R1 R2 early kick fault");
    cyc(10);
    expect_now(0, 1, 1, 0, 1, "R7 cause kept after own reset");

    // timeout
    wait_state(2, 80, "R1 timeout reaches safe");
    expect_now(2, 1, 2, 1, 0, "R2 timeout counted");
    cyc(10);
    expect_now(0, 1, 2, 0, 1, "R2 recovered after timeout");

    // third fault exceeds budget
    extf = 1'b1; cyc(1); extf = 1'b0;
    expect_now(3, 3, 3, 1, 0, "R5 lockout on budget exceeded");
    cyc(100);
    expect_now(3, 3, 3, 1, 0, "R6 no automatic restart");

    pgood = 1'b0; cyc(2); pulse_ack(); cyc(2);
    expect_now(3, 3, 3, 1, 0, "R6 ack ignored with power low");
    pgood = 1'b1; cyc(2); pulse_ack(); cyc(2);
    expect_now(3, 3, 3, 1, 0, "R6 ack ignored before stable");
    cyc(12); pulse_ack();
    expect_now(2, 3, 0, 1, 0, "R6 ack releases and clears retry");
    cyc(10);
    expect_now(0, 3, 0, 0, 1, "R7 cause survives release");

    // brownout
    cyc(5); pgood = 1'b0;
    expect_now(0, 3, 0, 1, 0, "R3 immediate safe force on power loss");
    cyc(1);
    expect_now(2, 2, 1, 1, 0, "R7 brownout cause");
    cyc(50);
    expect_now(2, 2, 1, 1, 0, "R4 reset held during brownout");
    pgood = 1'b1; cyc(5);
    expect_now(2, 2, 1, 1, 0, "R4 debounce after brownout");
    cyc(15);
    expect_now(0, 2, 1, 0, 1, "R4 release after brownout");

    // software fault
    cyc(3); swf = 1'b1; cyc(1); swf = 1'b0;
    expect_now(2, 4, 2, 1, 0, "R7 software cause");
    cyc(10);
    expect_now(0, 4, 2, 0, 1, "R2 recovered after software fault");

    // retry window expiry
    for (int k = 0; k < 90; k++) serve(24);
    cyc(1);
    expect_now(0, 4, 0, 0, 1, "R9 retry cleared after window");
    cyc(3); extf = 1'b1; cyc(1); extf = 1'b0;
    expect_now(2, 3, 1, 1, 0, "R9 count restarts at one");
    cyc(10);
    expect_now(0, 3, 1, 0, 1, "R9 run after restart fault");

    // priority: external over software in the same cycle
    cyc(3); extf = 1'b1; swf = 1'b1; cyc(1); extf = 1'b0; swf = 1'b0;
    expect_now(2, 3, 2, 1, 0, "R7 external wins over software");

    cyc(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule